// File: doc/BRIEF.md
# Freezable Performance Counter Unit

This block is a small performance monitor holding one 32-bit control register and two 32-bit counters with fixed roles. The retire counter accumulates the number of instructions completed each cycle. The cycle counter advances on every cycle tick. A single freeze bit in the control register starts and stops both counters together. A two-bit participation field can also exclude both counters while they are unfrozen.

Software freezes the unit, loads starting values into the counters, and clears the freeze bit to begin measuring. It sets the freeze bit again before it reads the totals. The control register has two write ports. A privileged port replaces the whole word. A user port can alter only three control bits and leaves every other bit as it was. Reads of all three registers are plain combinational outputs.

Top module: `pmon_unit`

## Requirements
- R1: After reset the control register reads 0x80000000, so the freeze bit (bit 31) is set, and both counters read 0.
- R2: While the freeze bit is 1, neither counter changes, except through a direct counter write.
- R3: While the freeze bit is 0 and the participation field is not 2'b11, the retire counter adds the retire input every cycle. Retire values above 4 are counted as 4. Counting in a cycle follows the control value held at the start of that cycle. A write that clears the freeze bit therefore starts counting in the next cycle, and a write that sets it still counts its own cycle.
- R4: Under the same run condition, the cycle counter adds 1 in each cycle in which the cycle tick is high, and holds otherwise.
- R5: When the participation field, control bits 19:18, equals 2'b11, both counters hold even with the freeze bit at 0. Any other value of the field lets them count.
- R6: A privileged control write replaces all 32 bits. If a privileged write and a user write fall in the same cycle, the privileged write wins.
- R7: A user control write changes only bit 31 (freeze), bit 26 (alert enable) and bit 7 (alert occurred). All other bits keep their previous values.
- R8: A counter write takes effect only when the freeze bit held at the start of that cycle is 1. Otherwise it is ignored and the counter keeps counting or holding as before.
- R9: Both counters wrap modulo 2^32.
- R10: All three read outputs show the register contents with no added latency. A value written or counted at a clock edge is visible right after that edge.
- R11: A control write that leaves the freeze bit unchanged neither starts nor stops counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_cnt | input | 3 | Instructions completed this cycle, 0 to 4 |
| cyc_tick | input | 1 | Cycle tick |
| priv_ctl_we | input | 1 | Privileged control write strobe |
| priv_ctl_wdata | input | 32 | Privileged control write data |
| user_ctl_we | input | 1 | User control write strobe |
| user_ctl_wdata | input | 32 | User control write data |
| cnt_a_we | input | 1 | Retire counter write strobe |
| cnt_a_wdata | input | 32 | Retire counter write data |
| cnt_b_we | input | 1 | Cycle counter write strobe |
| cnt_b_wdata | input | 32 | Cycle counter write data |
| ctl_rdata | output | 32 | Control register value |
| cnt_a_rdata | output | 32 | Retire counter value |
| cnt_b_rdata | output | 32 | Cycle counter value |

## Verification
The key coincidence is a control write that toggles the freeze bit landing in the same cycle as a counter write, or as active retire and tick inputs. The bench clears the freeze bit while loading the retire counter, and expects the loaded value with no increment added. It sets the freeze bit while retirements are arriving, and expects that cycle's count to be kept. It also issues privileged and user control writes in one cycle and expects the privileged word to win. A reference model in the driver predicts every cycle, including long random stretches where these events overlap freely.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int unsigned CTL_W    = 32;
  localparam int unsigned FRZ_BIT  = 31;
  localparam int unsigned AEN_BIT  = 26;
  localparam int unsigned AOC_BIT  = 7;
  localparam int unsigned PART_LO  = 18;
  localparam logic [CTL_W-1:0] CTL_RESET = 32'h8000_0000;
  localparam logic [CTL_W-1:0] USER_MASK =
    (32'h1 << FRZ_BIT) | (32'h1 << AEN_BIT) | (32'h1 << AOC_BIT);

  // keep non-user bits from cur, take user bits from wr
  function automatic logic [CTL_W-1:0] merge_user(input logic [CTL_W-1:0] cur,
                                                  input logic [CTL_W-1:0] wr);
    return (cur & ~USER_MASK) | (wr & USER_MASK);
  endfunction

  function automatic logic part_excluded(input logic [CTL_W-1:0] c);
    return c[PART_LO+1 -: 2] == 2'b11;
  endfunction
endpackage

// File: rtl/pmon_ctl.sv
module pmon_ctl
  import pmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             priv_we,
  input  logic [CTL_W-1:0] priv_wdata,
  input  logic             user_we,
  input  logic [CTL_W-1:0] user_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             frozen,
  output logic             count_en
);
  logic [CTL_W-1:0] ctl_next;
  logic             ev_freeze;
  logic             ev_thaw;

  always_comb begin
    if (priv_we)      ctl_next = priv_wdata;
    else if (user_we) ctl_next = merge_user(ctl_q, user_wdata);
    else              ctl_next = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_next;
  end

  assign frozen    = ctl_q[FRZ_BIT];
  assign count_en  = !frozen && !part_excluded(ctl_q);
  assign ev_freeze = !frozen && ctl_next[FRZ_BIT];
  assign ev_thaw   = frozen && !ctl_next[FRZ_BIT];

  a_r6_priv_full: assert property (@(posedge clk) disable iff (!rst_n)
    priv_we |=> ctl_q == $past(priv_wdata));
  a_r7_user_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (user_we && !priv_we) |=> ((ctl_q ^ $past(ctl_q)) & ~USER_MASK) == '0);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_we && !user_we) |=> $stable(ctl_q));
  a_r11_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_freeze && !ev_thaw) |=> frozen == $past(frozen));
  a_r3_thaw_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thaw |=> !frozen);
  a_r3_freeze_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_freeze |=> frozen);
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [INC_W-1:0] inc,
  input  logic             load_en,
  input  logic [W-1:0]     load_val,
  output logic [W-1:0]     value
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a,
                                            input logic [INC_W-1:0] b);
    return a + W'(b);
  endfunction

  logic [W-1:0] value_next;

  always_comb begin
    if (load_en)       value_next = load_val;
    else if (count_en) value_next = add_wrap(value, inc);
    else               value_next = value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= value_next;
  end

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> value == $past(load_val));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !load_en) |=> $stable(value));
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !load_en && value == ALL_ONES && inc != '0) |=> value < $past(value));
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned RETIRE_W   = 3,
  parameter int unsigned MAX_RETIRE = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RETIRE_W-1:0] retire_cnt,
  input  logic                cyc_tick,
  input  logic                priv_ctl_we,
  input  logic [CTL_W-1:0]    priv_ctl_wdata,
  input  logic                user_ctl_we,
  input  logic [CTL_W-1:0]    user_ctl_wdata,
  input  logic                cnt_a_we,
  input  logic [CNT_W-1:0]    cnt_a_wdata,
  input  logic                cnt_b_we,
  input  logic [CNT_W-1:0]    cnt_b_wdata,
  output logic [CTL_W-1:0]    ctl_rdata,
  output logic [CNT_W-1:0]    cnt_a_rdata,
  output logic [CNT_W-1:0]    cnt_b_rdata
);
  localparam logic [RETIRE_W-1:0] RET_CAP = RETIRE_W'(MAX_RETIRE);

  function automatic logic [RETIRE_W-1:0] clamp_retire(input logic [RETIRE_W-1:0] r);
    return (r > RET_CAP) ? RET_CAP : r;
  endfunction

  logic                frozen;
  logic                count_en;
  logic [RETIRE_W-1:0] retire_eff;
  logic                load_a;
  logic                load_b;

  assign retire_eff = clamp_retire(retire_cnt);
  assign load_a     = cnt_a_we && frozen;
  assign load_b     = cnt_b_we && frozen;

  pmon_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_we    (priv_ctl_we),
    .priv_wdata (priv_ctl_wdata),
    .user_we    (user_ctl_we),
    .user_wdata (user_ctl_wdata),
    .ctl_q      (ctl_rdata),
    .frozen     (frozen),
    .count_en   (count_en)
  );

  pmon_counter #(.W(CNT_W), .INC_W(RETIRE_W)) u_cnt_retire (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .inc      (retire_eff),
    .load_en  (load_a),
    .load_val (cnt_a_wdata),
    .value    (cnt_a_rdata)
  );

  pmon_counter #(.W(CNT_W), .INC_W(1)) u_cnt_cycle (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .inc      (cyc_tick),
    .load_en  (load_b),
    .load_val (cnt_b_wdata),
    .value    (cnt_b_rdata)
  );

  always_comb begin
    a_r3_clamp: assert (retire_eff <= RET_CAP);
  end

  a_r8_ignore_running: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a_we && !frozen && !count_en) |=> $stable(cnt_a_rdata));
  a_r5_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !count_en) |=> ($stable(cnt_a_rdata) && $stable(cnt_b_rdata)));
  a_r4_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && cyc_tick) |=> cnt_b_rdata == $past(cnt_b_rdata) + 1'b1);
  a_r2_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cnt_a_we && !cnt_b_we) |=> ($stable(cnt_a_rdata) && $stable(cnt_b_rdata)));
endmodule

// File: tb/pmon_unit_bench.sv
`timescale 1ns/1ps
module pmon_unit_bench;
  localparam logic [31:0] UMASK = 32'h8400_0080;

  typedef struct {
    string       tag;
    logic [31:0] c;
    logic [31:0] a;
    logic [31:0] b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  retire_cnt = '0;
  logic        cyc_tick = 1'b0;
  logic        priv_ctl_we = 1'b0;
  logic [31:0] priv_ctl_wdata = '0;
  logic        user_ctl_we = 1'b0;
  logic [31:0] user_ctl_wdata = '0;
  logic        cnt_a_we = 1'b0;
  logic [31:0] cnt_a_wdata = '0;
  logic        cnt_b_we = 1'b0;
  logic [31:0] cnt_b_wdata = '0;
  logic [31:0] ctl_rdata, cnt_a_rdata, cnt_b_rdata;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;
  exp_t q[$];
  logic [31:0] m_c, m_a, m_b;

  always #2.5 clk = ~clk;

  pmon_unit u_pmon_unit (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .cyc_tick(cyc_tick),
    .priv_ctl_we(priv_ctl_we), .priv_ctl_wdata(priv_ctl_wdata),
    .user_ctl_we(user_ctl_we), .user_ctl_wdata(user_ctl_wdata),
    .cnt_a_we(cnt_a_we), .cnt_a_wdata(cnt_a_wdata),
    .cnt_b_we(cnt_b_we), .cnt_b_wdata(cnt_b_wdata),
    .ctl_rdata(ctl_rdata), .cnt_a_rdata(cnt_a_rdata), .cnt_b_rdata(cnt_b_rdata)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // driver: drive one cycle of stimulus and push the model's prediction
  task automatic step(string tag, logic pw, logic [31:0] pd, logic uw, logic [31:0] ud,
                      logic aw, logic [31:0] ad, logic bw, logic [31:0] bd,
                      logic [2:0] ret, logic tick);
    logic frz, run;
    logic [31:0] reff;
    exp_t e;
    @(negedge clk);
    priv_ctl_we = pw; priv_ctl_wdata = pd; user_ctl_we = uw; user_ctl_wdata = ud;
    cnt_a_we = aw; cnt_a_wdata = ad; cnt_b_we = bw; cnt_b_wdata = bd;
    retire_cnt = ret; cyc_tick = tick;
    frz  = m_c[31];
    run  = !frz && (m_c[19:18] != 2'b11);
    reff = (ret > 3'd4) ? 32'd4 : {29'd0, ret};
    if (aw && frz) m_a = ad; else if (run) m_a = m_a + reff;
    if (bw && frz) m_b = bd; else if (run && tick) m_b = m_b + 32'd1;
    if (pw) m_c = pd; else if (uw) m_c = (m_c & ~UMASK) | (ud & UMASK);
    e.tag = tag; e.c = m_c; e.a = m_a; e.b = m_b;
    q.push_back(e);
  endtask

  task automatic idle(string tag, logic [2:0] ret, logic tick);
    step(tag, 0, '0, 0, '0, 0, '0, 0, '0, ret, tick);
  endtask

  // monitor: compare right after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "ctl", ctl_rdata, e.c);
        check(e.tag, "cnt_a", cnt_a_rdata, e.a);
        check(e.tag, "cnt_b", cnt_b_rdata, e.b);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_c = 32'h8000_0000; m_a = '0; m_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ctl", ctl_rdata, 32'h8000_0000);
    check("R1", "cnt_a", cnt_a_rdata, 32'd0);
    check("R1", "cnt_b", cnt_b_rdata, 32'd0);

    idle("R2 frozen after reset", 3'd3, 1);
    idle("R2 frozen hold", 3'd4, 1);
    step("R8 load while frozen R10", 0, '0, 0, '0, 1, 32'd100, 1, 32'hFFFF_FFFE, 3'd2, 1);
    // thaw in the same cycle as a counter load: load accepted, no increment yet
    step("R3 thaw with load R8", 1, 32'h0, 0, '0, 1, 32'd200, 0, '0, 3'd4, 1);
    idle("R3 count 1", 3'd1, 1);
    idle("R4 B wraps R9", 3'd0, 1);
    idle("R3 clamp 7 to 4", 3'd7, 0);
    idle("R4 no tick", 3'd3, 0);
    step("R8 load ignored running", 0, '0, 0, '0, 1, 32'd5, 1, 32'd5, 3'd2, 1);
    step("R11 rewrite freeze 0 R6", 1, 32'h0000_1234, 0, '0, 0, '0, 0, '0, 3'd2, 1);
    idle("R11 still counting", 3'd1, 1);
    step("R5 exclude set", 1, 32'h000C_0000, 0, '0, 0, '0, 0, '0, 3'd3, 1);
    idle("R5 excluded hold", 3'd4, 1);
    step("R5 excluded load ignored R8", 0, '0, 0, '0, 1, 32'd9, 0, '0, 3'd4, 1);
    step("R5 field 10 counts", 1, 32'h0008_0000, 0, '0, 0, '0, 0, '0, 3'd2, 1);
    idle("R5 field 10 running", 3'd2, 1);
    // user write sets freeze: this cycle still counts
    step("R7 user all ones R3", 0, '0, 1, 32'hFFFF_FFFF, 0, '0, 0, '0, 3'd3, 1);
    idle("R2 frozen by user", 3'd3, 1);
    step("R6 priv beats user", 1, 32'h8000_0001, 1, 32'h0000_0000, 0, '0, 0, '0, 3'd1, 1);
    step("R7 user clears freeze", 0, '0, 1, 32'h0000_0000, 0, '0, 0, '0, 3'd1, 1);
    idle("R7 running after user thaw", 3'd2, 1);
    step("R9 freeze", 1, 32'h8000_0000, 0, '0, 0, '0, 0, '0, 3'd0, 0);
    step("R9 load near max", 0, '0, 0, '0, 1, 32'hFFFF_FFFE, 0, '0, 3'd0, 0);
    step("R9 thaw", 1, 32'h0, 0, '0, 0, '0, 0, '0, 3'd0, 0);
    idle("R9 A wraps", 3'd4, 0);
    step("R11 user rewrite freeze 0", 0, '0, 1, 32'h0400_0000, 0, '0, 0, '0, 3'd1, 1);
    idle("R11 still running", 3'd1, 1);

    for (int i = 0; i < 400; i++) begin
      logic        pw, uw;
      logic [31:0] pd, ud;
      pw = ($urandom_range(0, 5) == 0);
      uw = ($urandom_range(0, 4) == 0);
      pd = $urandom & 32'h840C_00FF;
      ud = $urandom;
      if ($urandom_range(0, 1) == 0) pd[31] = 1'b0;
      step("R3 random R4 R5 R6 R7 R8", pw, pd, uw, ud,
           ($urandom_range(0, 3) == 0), $urandom, ($urandom_range(0, 3) == 0), $urandom,
           3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
    end

    idle("drain", 3'd0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule